// File: doc/BRIEF.md
# Quadratic Polynomial Execute Unit

This unit is an execute-stage resource for a pipelined processor. It computes A·X² + B·X + C as one issued instruction, so a routine of several multiplies, adds and register moves becomes a single operation. The decode stage reads the four operands from the register file and passes them in together with the number of the destination register. A one-cycle start strobe hands the job to the unit.

The unit takes its operands and the destination number at the edge that accepts the start. It then works through three execute cycles in Horner order:

1. multiply A by X;
2. add B to that product and multiply the sum by X;
3. add C.

During those three cycles a busy output tells the pipeline controller to keep the instructions behind this one in their stages. In the following cycle a done strobe presents the result and its write address for the register-file write port.

All arithmetic is 16-bit two's complement. Each product and sum is truncated to its low 16 bits.

Top module: `quad_eval_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, busy and done are 0, and result and wr_addr are 0.
- R2: A start seen while busy is 0 is accepted at that clock edge. busy is then 1 for exactly the three cycles that follow that edge and 0 in the fourth.
- R3: done is 1 for exactly one cycle, the first cycle after the three busy cycles. It is never 1 while busy is 1.
- R4: In the done cycle, result equals (op_a·op_x·op_x + op_b·op_x + op_c) mod 2^16, using the operands sampled at the accepting edge. Because this is modular arithmetic, a 16-bit two's complement value such as 0xFFFF (−1) wraps correctly.
- R5: In the done cycle, wr_addr equals the dest_in value sampled at the accepting edge.
- R6: Changes to op_a, op_b, op_c, op_x and dest_in after the accepting edge have no effect on the result or wr_addr of the job in progress.
- R7: A start strobe that arrives while busy is 1 is ignored. It produces no extra busy cycles and no extra done pulse.
- R8: A start given in the done cycle is accepted, so busy is 1 in the very next cycle.
- R9: result and wr_addr keep their values in every cycle in which done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue strobe for one quadratic instruction |
| op_a | input | 16 | Coefficient of X squared |
| op_b | input | 16 | Coefficient of X |
| op_c | input | 16 | Constant term |
| op_x | input | 16 | Variable value |
| dest_in | input | 4 | Destination register number |
| busy | output | 1 | Stall request to the pipeline controller |
| done | output | 1 | One-cycle completion strobe |
| result | output | 16 | Polynomial value, valid while done is 1 |
| wr_addr | output | 4 | Destination register number, valid while done is 1 |

## Verification
The directed operand sets each isolate one term of the polynomial:
- all-zero operands;
- A equal to zero (the linear path only);
- X equal to zero (only C survives);
- X equal to −1 (the result reduces to A − B + C, which exposes sign and wrap handling);
- extreme values 0x7FFF and 0x8000 (these force truncation in both products).

Random operand sets run with and without interference. With interference, the operand and destination inputs are scrambled and start is strobed during the busy cycles. This tells a design that resamples its inputs, or restarts, apart from one that latches them once.

A back-to-back issue in the done cycle separates correct acceptance timing from an off-by-one in the sequencer. The cycle after each done shows whether the result register stays unchanged.

// File: rtl/quad_pkg.sv
package quad_pkg;

    localparam int unsigned QW_DATA = 16;
    localparam int unsigned QW_ADDR = 4;

    // Execute step of the Horner evaluation
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,   // acc = A * X
        ST_FOLD = 2'd2,   // acc = (acc + B) * X
        ST_ADD  = 2'd3    // res = acc + C
    } step_e;

    typedef struct packed {
        step_e step;
        logic  done;
    } ctrl_s;

endpackage

// File: rtl/quad_ctrl.sv
module quad_ctrl
    import quad_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    output logic  accept,
    output step_e step,
    output logic  busy,
    output logic  done
);

    ctrl_s st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        accept    = 1'b0;
        unique case (st_q.step)
            ST_IDLE: begin
                if (start) begin
                    st_d.step = ST_MUL;
                    accept    = 1'b1;
                end
            end
            ST_MUL:  st_d.step = ST_FOLD;
            ST_FOLD: st_d.step = ST_ADD;
            ST_ADD: begin
                st_d.step = ST_IDLE;
                st_d.done = 1'b1;
            end
            default: st_d.step = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{step: ST_IDLE, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign step = st_q.step;
    assign busy = (st_q.step != ST_IDLE);
    assign done = st_q.done;

    // R2: a busy window is exactly three cycles long
    a_r2_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(busy, 2) && $past(busy, 3) && !$past(busy, 4)));

    // R8: a start seen while idle is taken at once
    a_r8_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R3: done is a single pulse following the busy window
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r3_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

endmodule

// File: rtl/quad_mac.sv
module quad_mac #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] addend_a,
    input  logic [W-1:0] addend_b,
    input  logic [W-1:0] factor,
    output logic [W-1:0] product
);

    logic [W-1:0] sum;

    // Modular add-then-multiply, low W bits kept
    assign sum     = addend_a + addend_b;
    assign product = sum * factor;

endmodule

// File: rtl/quad_dpath.sv
module quad_dpath
    import quad_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  step_e             step,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic [DATA_W-1:0] in_c,
    input  logic [DATA_W-1:0] in_x,
    input  logic [ADDR_W-1:0] in_dst,
    output logic [DATA_W-1:0] res,
    output logic [ADDR_W-1:0] res_dst
);

    typedef struct packed {
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic [DATA_W-1:0] c;
        logic [DATA_W-1:0] x;
        logic [ADDR_W-1:0] dst;
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] res;
        logic [ADDR_W-1:0] res_dst;
    } dp_s;

    dp_s dp_d, dp_q;

    logic [DATA_W-1:0] mac_p, mac_q, mac_y;

    // One shared multiplier serves both product steps
    assign mac_p = (step == ST_MUL) ? dp_q.a : dp_q.acc;
    assign mac_q = (step == ST_MUL) ? '0     : dp_q.b;

    quad_mac #(.W(DATA_W)) u_mac (
        .addend_a (mac_p),
        .addend_b (mac_q),
        .factor   (dp_q.x),
        .product  (mac_y)
    );

    always_comb begin
        dp_d = dp_q;
        if (accept) begin
            dp_d.a   = in_a;
            dp_d.b   = in_b;
            dp_d.c   = in_c;
            dp_d.x   = in_x;
            dp_d.dst = in_dst;
        end
        unique case (step)
            ST_MUL, ST_FOLD: dp_d.acc = mac_y;
            ST_ADD: begin
                dp_d.res     = dp_q.acc + dp_q.c;
                dp_d.res_dst = dp_q.dst;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign res     = dp_q.res;
    assign res_dst = dp_q.res_dst;

    // R6: latched operands do not move during evaluation
    a_r6_operands_held: assert property (@(posedge clk) disable iff (!rst_n)
        (step == ST_FOLD || step == ST_ADD) |-> ($stable(dp_q.x) && $stable(dp_q.c) && $stable(dp_q.dst)));

endmodule

// File: rtl/quad_eval_unit.sv
module quad_eval_unit
    import quad_pkg::*;
#(
    parameter int unsigned DATA_W = QW_DATA,
    parameter int unsigned ADDR_W = QW_ADDR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [DATA_W-1:0] op_c,
    input  logic [DATA_W-1:0] op_x,
    input  logic [ADDR_W-1:0] dest_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic [ADDR_W-1:0] wr_addr
);

    logic  accept;
    step_e step;

    quad_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .accept (accept),
        .step   (step),
        .busy   (busy),
        .done   (done)
    );

    quad_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dpath (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .step    (step),
        .in_a    (op_a),
        .in_b    (op_b),
        .in_c    (op_c),
        .in_x    (op_x),
        .in_dst  (dest_in),
        .res     (result),
        .res_dst (wr_addr)
    );

    // R9: outputs only move together with a done pulse
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(result) && $stable(wr_addr)));

    // R7: no new busy window can open while one is running
    a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && step == ST_ADD) |=> (!busy && done));

endmodule

// File: tb/quad_eval_unit_test.sv
`timescale 1ns/1ps
module quad_eval_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] op_a = '0, op_b = '0, op_c = '0, op_x = '0;
    logic [3:0]  dest_in = '0;
    logic        busy, done;
    logic [15:0] result;
    logic [3:0]  wr_addr;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    int unsigned cyc = 0;

    always #4 clk = ~clk;

    quad_eval_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op_a(op_a), .op_b(op_b), .op_c(op_c), .op_x(op_x),
        .dest_in(dest_in), .busy(busy), .done(done),
        .result(result), .wr_addr(wr_addr)
    );

    function automatic logic [15:0] model(input logic [15:0] a, b, c, x);
        logic [31:0] t;
        t = 32'(a) * 32'(x) * 32'(x) + 32'(b) * 32'(x) + 32'(c);
        return t[15:0];
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cyc++;
    endtask

    task automatic load(input logic [15:0] a, b, c, x, input logic [3:0] d);
        op_a = a; op_b = b; op_c = c; op_x = x; dest_in = d;
    endtask

    // Issue one job at the current negedge; optionally disturb inputs while busy.
    // Returns at the negedge of the done cycle.
    task automatic issue(input logic [15:0] a, b, c, x, input logic [3:0] d, input bit noisy);
        load(a, b, c, x, d);
        start = 1'b1;
        tick();
        start = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk("R2 busy during execute", 16'(busy), 16'd1);
            chk("R3 no done while busy", 16'(done), 16'd0);
            if (noisy) begin
                load(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), 4'($urandom));
                start = 1'b1;   // R7: must be ignored
            end
            tick();
            start = 1'b0;
        end
        chk("R2 busy low after three cycles", 16'(busy), 16'd0);
        chk("R3 done pulse", 16'(done), 16'd1);
        chk("R4 result", result, model(a, b, c, x));
        chk("R5 write address", 16'(wr_addr), 16'(d));
    endtask

    task automatic after_done(input logic [15:0] exp_res, input logic [3:0] exp_d);
        tick();
        chk("R3 done is one cycle", 16'(done), 16'd0);
        chk("R7 no restart from ignored start", 16'(busy), 16'd0);
        chk("R9 result held", result, exp_res);
        chk("R9 address held", 16'(wr_addr), 16'(exp_d));
    endtask

    task automatic job(input logic [15:0] a, b, c, x, input logic [3:0] d, input bit noisy);
        issue(a, b, c, x, d, noisy);
        after_done(model(a, b, c, x), d);
    endtask

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd7351);
        @(negedge clk);
        tick();
        chk("R1 busy in reset", 16'(busy), 16'd0);
        chk("R1 done in reset", 16'(done), 16'd0);
        rst_n = 1'b1;
        tick();
        chk("R1 busy after reset", 16'(busy), 16'd0);
        chk("R1 result after reset", result, 16'h0000);
        chk("R1 address after reset", 16'(wr_addr), 16'd0);

        // Directed corners (R4)
        job(16'h0000, 16'h0000, 16'h0000, 16'h0000, 4'd1, 1'b0);
        job(16'h0000, 16'h0005, 16'h0003, 16'h0007, 4'd2, 1'b0);   // linear only
        job(16'h1234, 16'h5678, 16'h9ABC, 16'h0000, 4'd3, 1'b0);   // X = 0 gives C
        job(16'h0009, 16'h0004, 16'h0002, 16'hFFFF, 4'd4, 1'b0);   // X = -1
        job(16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF, 4'd15, 1'b0);
        job(16'h8000, 16'h8000, 16'h8000, 16'h8000, 4'd0, 1'b0);
        job(16'hFFFE, 16'h0003, 16'hFFFF, 16'h0002, 4'd9, 1'b1);    // R6/R7

        // R8: back-to-back issue in the done cycle
        issue(16'h0002, 16'h0003, 16'h0004, 16'h0005, 4'd6, 1'b0);
        load(16'h0011, 16'h0022, 16'h0033, 16'h0044, 4'd7);
        start = 1'b1;
        tick();
        start = 1'b0;
        chk("R8 busy right after done-cycle start", 16'(busy), 16'd1);
        chk("R9 previous result held", result, model(16'h0002, 16'h0003, 16'h0004, 16'h0005));
        tick(); tick(); tick();
        chk("R8 second job done", 16'(done), 16'd1);
        chk("R8 second job result", result, model(16'h0011, 16'h0022, 16'h0033, 16'h0044));
        chk("R5 second job address", 16'(wr_addr), 16'd7);
        tick();

        // Random jobs, half with input interference (R4, R6, R7)
        for (int i = 0; i < 60; i++) begin
            job(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
                4'($urandom), 1'(i % 2));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule